// File: doc/BRIEF.md
# Pipeline Operand Bypass and Taken-Branch Squash Controller

This block is the hazard controller of a single-issue, in-order 32-bit integer pipeline that fetches one instruction every cycle. It owns the fetch program counter and presents the matching word address to the instruction memory. It sits beside the execute stage and does three things there. It chooses, for each of the two source operands, between the register-file read data and the result of the instruction that executed one cycle earlier. It marks each executing instruction valid or squashed. It produces the registered write-back port of the register file.

The pipeline has three stages. An instruction is fetched in cycle c, reads its operands in cycle c+1 and executes in cycle c+2. The register file is read combinationally, and it is written at the clock edge while the write-back port is enabled. The instruction that executed one cycle earlier is therefore not yet in the register file, and its result is taken from the write-back register instead.

There is no prediction. Fetch always steps by 4. When a valid branch resolves taken in execute, the next fetch address is the branch target. The two instructions already fetched behind that branch are squashed.

Top module: `bypass_squash_ctrl`

## Requirements
- R1: Outside reset the fetch PC increases by 4 every cycle unless a redirect occurs. The instruction-memory word address is fetch PC bits [9:2]. The instruction-memory read enable is low while reset is high and high otherwise.
- R2: When the executing instruction is valid and `ex_taken` is high, the fetch PC in the next cycle equals `ex_target`. An instruction fetched in cycle c redirects fetch so that the target is fetched in cycle c+3.
- R3: Reset is synchronous and active high. In the first cycle after reset the fetch PC is 0. The two execute slots that follow reset are marked invalid, and the instruction at address 0 is the first valid one.
- R4: Each source operand is handled on its own. It takes the write-back data when the write-back enable is high and the write-back index equals that source index. Otherwise it takes the register-file read data.
- R5: The two instructions that execute in the two cycles after a valid taken branch are squashed (`ex_valid` low). The instruction after them is valid again.
- R6: A squashed instruction with `ex_taken` high does not redirect fetch. The fetch PC keeps stepping by 4.
- R7: The write-back port is registered and reflects the instruction that executed one cycle earlier. Its enable is high only when that instruction was valid, had a destination (`ex_has_rd` high) and its destination index was not 0.
- R8: Write-back data equals the ALU result when the write-back enable is high, and is 0 when the enable is low.
- R9: A program whose loop chains dependent adds back to back, closed by a taken branch, leaves 45 (the sum of 1 to 9) in its accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rd_en | output | 1 | Instruction-memory read enable |
| imem_addr | output | 8 | Instruction-memory word address (PC/4) |
| fetch_pc | output | 32 | Current fetch program counter |
| ex_rs1 | input | 5 | First source register index of the executing instruction |
| ex_rs2 | input | 5 | Second source register index of the executing instruction |
| ex_rd | input | 5 | Destination register index of the executing instruction |
| ex_has_rd | input | 1 | Executing instruction's format has a destination |
| rf_rd_data1 | input | 32 | Register-file read data for ex_rs1 |
| rf_rd_data2 | input | 32 | Register-file read data for ex_rs2 |
| alu_result | input | 32 | ALU result of the executing instruction |
| ex_taken | input | 1 | Executing instruction is a branch resolved taken |
| ex_target | input | 32 | Branch target (branch PC plus immediate) |
| opnd1 | output | 32 | Selected first operand to the ALU |
| opnd2 | output | 32 | Selected second operand to the ALU |
| ex_valid | output | 1 | Executing instruction is on the correct path |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |

## Verification
Some properties are checked in every cycle: the PC step and redirect, the zero PC after reset, and the two squash cycles after every valid taken branch. The operand mux is checked against the write-back register, and so are the write-back rules: no write to register 0, no write from a squashed slot, and zero data while disabled. The directed scenarios show what a single cycle cannot. They show the exact fetch address three cycles after a branch is fetched, and that a taken branch in the shadow of another leaves fetch sequential. They also show that forwarded values reach the register file through chains of back-to-back dependent instructions, ending in the 45 that the accumulating loop produces.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  // Sequential fetch stride in bytes.
  localparam int unsigned PC_STEP = 4;
  // Number of operand sources per instruction.
  localparam int unsigned N_SRC = 2;

  typedef enum logic {
    SRC_REGFILE = 1'b0,
    SRC_FORWARD = 1'b1
  } opnd_src_e;
endpackage

// File: rtl/bsc_fetch.sv
module bsc_fetch #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               redir_en,
  input  logic [XLEN-1:0]    redir_pc,
  output logic [XLEN-1:0]    pc_q,
  output logic               imem_rd_en,
  output logic [IMEM_AW-1:0] imem_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(bsc_pkg::PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= '0;
    else if (redir_en) pc_q <= redir_pc;
    else               pc_q <= pc_q + STEP;
  end

  assign imem_rd_en = !rst;
  assign imem_addr  = pc_q[IMEM_AW+1:2];

  // R1: sequential step when no redirect is requested
  a_r1_seq_step: assert property (@(posedge clk) disable iff (rst)
    !redir_en |=> pc_q == $past(pc_q) + STEP);

  // R2: redirect lands on the supplied target
  a_r2_redirect_target: assert property (@(posedge clk) disable iff (rst)
    redir_en |=> pc_q == $past(redir_pc));

  // R3: the cycle after a reset edge starts at address zero
  a_r3_reset_pc_zero: assert property (@(posedge clk)
    rst |=> pc_q == '0);
endmodule

// File: rtl/bsc_squash.sv
module bsc_squash #(
  parameter int unsigned KILL_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ex_taken,
  output logic ex_valid,
  output logic redirect
);
  localparam int unsigned WARM_W = $clog2(KILL_DEPTH + 1);
  localparam logic [WARM_W-1:0] WARM_FULL = WARM_W'(KILL_DEPTH);

  logic [WARM_W-1:0]     warm_q;
  logic [KILL_DEPTH-1:0] shadow_q;

  // A slot is live once the pipe has filled and no recent redirect shadows it.
  assign ex_valid = (warm_q == WARM_FULL) && (shadow_q == '0);
  assign redirect = ex_taken && ex_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (warm_q != WARM_FULL) warm_q <= warm_q + WARM_W'(1);
      shadow_q <= (shadow_q << 1) | KILL_DEPTH'(redirect);
    end
  end

  // R5: the slot right behind a redirect is squashed
  a_r5_kill_first: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !ex_valid);

  generate
    if (KILL_DEPTH >= 2) begin : g_second
      // R5: the second slot behind a redirect is squashed too
      a_r5_kill_second: assert property (@(posedge clk) disable iff (rst)
        $past(redirect, 2) |-> !ex_valid);
    end
  endgenerate

  // R3: the first slot after reset is never live
  a_r3_warmup: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ex_valid);
endmodule

// File: rtl/bsc_fwd_mux.sv
module bsc_fwd_mux #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rs_idx,
  input  logic [XLEN-1:0]   rf_data,
  input  logic              fwd_en,
  input  logic [RIDX_W-1:0] fwd_idx,
  input  logic [XLEN-1:0]   fwd_data,
  output logic [XLEN-1:0]   opnd
);
  bsc_pkg::opnd_src_e sel;

  always_comb begin
    sel = (fwd_en && (fwd_idx == rs_idx)) ? bsc_pkg::SRC_FORWARD
                                          : bsc_pkg::SRC_REGFILE;
    case (sel)
      bsc_pkg::SRC_FORWARD: opnd = fwd_data;
      default:              opnd = rf_data;
    endcase
  end

  // R4: no matching producer, operand comes from the register file
  a_r4_regfile_path: assert property (@(posedge clk) disable iff (rst)
    !(fwd_en && fwd_idx == rs_idx) |-> opnd == rf_data);

  // R4: matching producer, operand comes from the write-back register
  a_r4_forward_path: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && fwd_idx == rs_idx) |-> opnd == fwd_data);
endmodule

// File: rtl/bsc_writeback.sv
module bsc_writeback #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ex_valid,
  input  logic              ex_has_rd,
  input  logic [RIDX_W-1:0] ex_rd,
  input  logic [XLEN-1:0]   alu_result,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  logic en_d;

  assign en_d = ex_valid && ex_has_rd && (ex_rd != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= en_d;
      wb_idx  <= ex_rd;
      wb_data <= en_d ? alu_result : '0;
    end
  end

  // R7: register zero is never a write target
  a_r7_no_zero_dest: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> wb_idx != '0);

  // R7: a squashed slot produces no write
  a_r7_invalid_blocks: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> !wb_en);

  // R8: idle write port carries zero data
  a_r8_zero_data: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> wb_data == '0);
endmodule

// File: rtl/bypass_squash_ctrl.sv
module bypass_squash_ctrl #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RIDX_W     = 5,
  parameter int unsigned IMEM_AW    = 8,
  parameter int unsigned KILL_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  output logic               imem_rd_en,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [XLEN-1:0]    fetch_pc,
  input  logic [RIDX_W-1:0]  ex_rs1,
  input  logic [RIDX_W-1:0]  ex_rs2,
  input  logic [RIDX_W-1:0]  ex_rd,
  input  logic               ex_has_rd,
  input  logic [XLEN-1:0]    rf_rd_data1,
  input  logic [XLEN-1:0]    rf_rd_data2,
  input  logic [XLEN-1:0]    alu_result,
  input  logic               ex_taken,
  input  logic [XLEN-1:0]    ex_target,
  output logic [XLEN-1:0]    opnd1,
  output logic [XLEN-1:0]    opnd2,
  output logic               ex_valid,
  output logic               rf_wr_en,
  output logic [RIDX_W-1:0]  rf_wr_idx,
  output logic [XLEN-1:0]    rf_wr_data
);
  localparam int unsigned NS = bsc_pkg::N_SRC;
  localparam logic [XLEN-1:0] STEP = XLEN'(bsc_pkg::PC_STEP);

  logic redirect;
  logic [NS-1:0][RIDX_W-1:0] src_idx;
  logic [NS-1:0][XLEN-1:0]   src_rf;
  logic [NS-1:0][XLEN-1:0]   src_out;

  assign src_idx = {ex_rs2, ex_rs1};
  assign src_rf  = {rf_rd_data2, rf_rd_data1};
  assign opnd1   = src_out[0];
  assign opnd2   = src_out[1];

  bsc_fetch #(.XLEN(XLEN), .IMEM_AW(IMEM_AW)) u_fetch (
    .clk(clk), .rst(rst),
    .redir_en(redirect), .redir_pc(ex_target),
    .pc_q(fetch_pc), .imem_rd_en(imem_rd_en), .imem_addr(imem_addr)
  );

  bsc_squash #(.KILL_DEPTH(KILL_DEPTH)) u_squash (
    .clk(clk), .rst(rst), .ex_taken(ex_taken),
    .ex_valid(ex_valid), .redirect(redirect)
  );

  generate
    for (genvar s = 0; s < NS; s++) begin : g_src
      bsc_fwd_mux #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_mux (
        .clk(clk), .rst(rst),
        .rs_idx(src_idx[s]), .rf_data(src_rf[s]),
        .fwd_en(rf_wr_en), .fwd_idx(rf_wr_idx), .fwd_data(rf_wr_data),
        .opnd(src_out[s])
      );
    end
  endgenerate

  bsc_writeback #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_wb (
    .clk(clk), .rst(rst),
    .ex_valid(ex_valid), .ex_has_rd(ex_has_rd), .ex_rd(ex_rd),
    .alu_result(alu_result),
    .wb_en(rf_wr_en), .wb_idx(rf_wr_idx), .wb_data(rf_wr_data)
  );

  // R6: a squashed slot leaves fetch on its sequential course
  a_r6_squashed_no_redirect: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> fetch_pc == $past(fetch_pc) + STEP);
endmodule

// File: tb/sim_bypass_squash_ctrl.sv
module sim_bypass_squash_ctrl;
  localparam int CLK_P = 10;
  localparam int NT    = 128;

  typedef enum logic [2:0] {OP_NOP, OP_ADD, OP_ADDI, OP_BEQ, OP_BNE} op_e;
  typedef struct packed {
    op_e         op;
    logic [4:0]  rd, rs1, rs2;
    logic [31:0] imm;
  } ins_t;
  typedef struct packed {
    ins_t        i;
    logic [31:0] pc;
  } slot_t;

  logic clk = 1'b0, rst = 1'b1, rf_clear = 1'b0;
  logic imem_rd_en, ex_has_rd, ex_taken, ex_valid, rf_wr_en;
  logic [7:0]  imem_addr;
  logic [4:0]  rf_wr_idx;
  logic [31:0] fetch_pc, rf1, rf2, alu, target, opnd1, opnd2, rf_wr_data;

  ins_t  prog [256];
  logic [31:0] rf [32];
  slot_t s_rd, s_ex;

  logic [31:0] tr_pc [NT];
  logic        tr_vld [NT];
  int n_chk = 0, n_fail = 0, zero_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bypass_squash_ctrl u0 (
    .clk(clk), .rst(rst), .imem_rd_en(imem_rd_en), .imem_addr(imem_addr),
    .fetch_pc(fetch_pc), .ex_rs1(s_ex.i.rs1), .ex_rs2(s_ex.i.rs2),
    .ex_rd(s_ex.i.rd), .ex_has_rd(ex_has_rd), .rf_rd_data1(rf1),
    .rf_rd_data2(rf2), .alu_result(alu), .ex_taken(ex_taken),
    .ex_target(target), .opnd1(opnd1), .opnd2(opnd2), .ex_valid(ex_valid),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
  );

  // Environment: fetch -> operand read -> execute, plus register file.
  always @(posedge clk) begin
    if (rst) begin
      s_rd <= '0;
      s_ex <= '0;
    end else begin
      s_rd <= '{i: prog[imem_addr], pc: fetch_pc};
      s_ex <= s_rd;
    end
  end

  always @(posedge clk) begin
    if (rf_clear) begin
      for (int k = 0; k < 32; k++) rf[k] <= '0;
    end else if (rf_wr_en) begin
      rf[rf_wr_idx] <= rf_wr_data;
    end
  end

  assign rf1       = rf[s_ex.i.rs1];
  assign rf2       = rf[s_ex.i.rs2];
  assign target    = s_ex.pc + s_ex.i.imm;
  assign ex_has_rd = (s_ex.i.op == OP_ADD) || (s_ex.i.op == OP_ADDI);

  always_comb begin
    case (s_ex.i.op)
      OP_ADDI: alu = opnd1 + s_ex.i.imm;
      default: alu = opnd1 + opnd2;
    endcase
    ex_taken = ((s_ex.i.op == OP_BEQ) && (opnd1 == opnd2)) ||
               ((s_ex.i.op == OP_BNE) && (opnd1 != opnd2));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int k = 0; k < 256; k++) prog[k] = '{op: OP_NOP, default: '0};
  endtask

  task automatic put(input int pc, input op_e op, input int rd, input int rs1,
                     input int rs2, input int imm);
    prog[pc/4] = '{op: op, rd: 5'(rd), rs1: 5'(rs1), rs2: 5'(rs2), imm: 32'(imm)};
  endtask

  // Reset, clear the register file, release, record n cycles (cycle 0 = first after reset).
  task automatic run(input int n);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rf_clear = 1'b1;
    @(negedge clk); rf_clear = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      tr_pc[k]  = fetch_pc;
      tr_vld[k] = ex_valid;
      if (!rf_wr_en && rf_wr_data != 0) zero_bad++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_fetch();
    clear_prog();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 read enable low in reset", 32'(imem_rd_en), 0);
    chk("R7 no write in reset", 32'(rf_wr_en), 0);
    chk("R3 pc zero in reset", fetch_pc, 0);
    run(8);
    chk("R3 pc zero first cycle", tr_pc[0], 0);
    chk("R1 pc step cycle 1", tr_pc[1], 4);
    chk("R1 pc step cycle 5", tr_pc[5], 20);
    chk("R3 slot 0 invalid", 32'(tr_vld[0]), 0);
    chk("R3 slot 1 invalid", 32'(tr_vld[1]), 0);
    chk("R3 slot 2 valid", 32'(tr_vld[2]), 1);
    #1;
    chk("R1 read enable high", 32'(imem_rd_en), 1);
    chk("R1 word address", 32'(imem_addr), fetch_pc >> 2);
  endtask

  task automatic t_forward();
    clear_prog();
    put(0,  OP_ADDI, 1, 0, 0, 7);
    put(4,  OP_ADD,  2, 1, 0, 0);
    put(8,  OP_ADD,  3, 0, 2, 0);
    put(12, OP_ADD,  4, 3, 3, 0);
    put(16, OP_ADDI, 0, 0, 0, 9);
    put(20, OP_ADD,  5, 0, 0, 0);
    put(24, OP_BEQ,  6, 0, 1, 100);
    put(28, OP_ADD,  7, 6, 0, 0);
    put(32, OP_ADD,  8, 7, 4, 0);
    zero_bad = 0;
    run(20);
    chk("R4 first source forwarded", rf[2], 7);
    chk("R4 second source forwarded", rf[3], 7);
    chk("R4 both sources forwarded", rf[4], 14);
    chk("R7 register 0 never written", rf[0], 0);
    chk("R4 no forward from register 0", rf[5], 0);
    chk("R7 branch has no destination", rf[6], 0);
    chk("R7 no forward from branch slot", rf[7], 0);
    chk("R4 mixed forward and file read", rf[8], 14);
    chk("R8 idle write data zero", 32'(zero_bad), 0);
  endtask

  task automatic t_branch_kill();
    clear_prog();
    put(0,  OP_ADDI, 1, 0, 0, 1);
    put(4,  OP_BEQ,  0, 0, 0, 16);
    put(8,  OP_ADDI, 2, 0, 0, 5);
    put(12, OP_ADDI, 3, 0, 0, 6);
    put(16, OP_ADDI, 4, 0, 0, 7);
    put(20, OP_ADDI, 5, 0, 0, 9);
    run(14);
    chk("R2 redirect three cycles after fetch", tr_pc[4], 20);
    chk("R2 sequential after target", tr_pc[5], 24);
    chk("R5 branch slot valid", 32'(tr_vld[3]), 1);
    chk("R5 first shadow squashed", 32'(tr_vld[4]), 0);
    chk("R5 second shadow squashed", 32'(tr_vld[5]), 0);
    chk("R5 target slot valid", 32'(tr_vld[6]), 1);
    chk("R5 squashed write 1", rf[2], 0);
    chk("R5 squashed write 2", rf[3], 0);
    chk("R2 skipped instruction", rf[4], 0);
    chk("R2 target executed", rf[5], 9);
  endtask

  task automatic t_kill_no_redirect();
    clear_prog();
    put(0,  OP_BEQ,  0, 0, 0, 32);
    put(4,  OP_BEQ,  0, 0, 0, 60);
    put(32, OP_ADDI, 6, 0, 0, 3);
    put(36, OP_BEQ,  0, 0, 0, 0);
    put(64, OP_ADDI, 7, 0, 0, 4);
    run(30);
    chk("R6 shadow slot squashed", 32'(tr_vld[3]), 0);
    chk("R6 no second redirect", tr_pc[4], 36);
    chk("R6 target path executed", rf[6], 3);
    chk("R6 spurious target never run", rf[7], 0);
  endtask

  task automatic t_sum_loop();
    clear_prog();
    put(0,  OP_ADDI, 1,  0,  0, 9);
    put(4,  OP_ADDI, 10, 0,  0, 0);
    put(8,  OP_ADD,  10, 10, 1, 0);
    put(12, OP_ADDI, 1,  1,  0, -1);
    put(16, OP_BNE,  0,  1,  0, -8);
    put(20, OP_ADDI, 11, 10, 0, 0);
    put(24, OP_BEQ,  0,  0,  0, 0);
    run(100);
    chk("R9 accumulator sum", rf[10], 45);
    chk("R9 copy after loop", rf[11], 45);
    chk("R9 counter exhausted", rf[1], 0);
  endtask

  initial begin
    t_reset_fetch();
    t_forward();
    t_branch_kill();
    t_kill_no_redirect();
    t_sum_loop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule